// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches a bank of general-purpose input pins and turns activity on them into interrupt requests. Every pin is configured on its own: level or edge sensitive; active high or active low when level sensitive; rising, falling or both edges when edge sensitive; and, for edge mode, whether a detected event is held until software clears it or only pulses for one cycle. Pins are grouped into 16-bit register words, so the default 32 pins form a low word (pins 0-15) and a high word (pins 16-31).

Software programs the configuration through a simple word-wide read/write port. It watches a pending-status word per group, clears held events by writing ones, and unmasks sources through an enable word. The block drives a single registered request line. Alongside the request it gives the number of the lowest pin that is both pending and enabled, and a valid flag. When the request is raised but no source qualifies, the flag is low, so the handler can detect a spurious request.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads 0 (level mode, active low, no hold, no edge selected, nothing enabled), and irq and vec_valid are 0 once the synchronized pins are inactive.
- R2: When a pin's type bit (word 0x10 low / 0x12 high) is 0, its status bit follows the level condition: pin equals its active-level bit (word 0x14/0x16, 1 = active high). The status bit is updated on the third rising clock edge after the pin changes, or one edge after the active-level bit is written. The hold bit has no effect in this mode.
- R3: When the type bit is 1, a rising edge sets status only if the rise-select bit (word 0x24/0x26) is set, and a falling edge sets status only if the fall-select bit (word 0x20/0x22) is set. With both bits set, either edge sets status. The status bit sets on the third rising clock edge after the pin change.
- R4: In edge mode with the hold bit (word 0x18/0x1A) at 1, status stays set until it is cleared. With the hold bit at 0, status is high for exactly one cycle per event.
- R5: Writing the status word (0x08 low / 0x0A high) clears each bit written as 1. Bits written as 0 are unchanged.
- R6: If a clear and a new edge event reach the same status bit on the same clock edge, the bit ends up set.
- R7: irq is the OR over all pins of (status AND enable, word 0x0C/0x0E). It is registered, so it changes one clock edge after status or enable changes.
- R8: vec_pin gives the lowest-numbered pin with status and enable both set. Every low-word pin is chosen before any high-word pin. The value is combinational from status and enable.
- R9: When no pin has status and enable both set, vec_valid is 0 and vec_pin is 0, even if status bits are pending.
- R10: Every configuration word reads back the value last written to it. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | NPINS | Asynchronous pin inputs |
| bus_we | input | 1 | Write strobe for the register port |
| bus_addr | input | 6 | Byte address of a 16-bit register (bit 0 ignored) |
| bus_wdata | input | REG_W | Write data |
| bus_rdata | output | REG_W | Combinational read data for bus_addr |
| irq | output | 1 | Registered combined interrupt request |
| vec_valid | output | 1 | A pending and enabled source exists |
| vec_pin | output | $clog2(NPINS) | Index of the winning pin |

## Verification
A pin change driven at a falling clock edge passes through two synchronizer flops. The status bit therefore changes on the third rising edge that follows, and the bench samples half a nanosecond after that edge. It also checks that the bit has not yet changed one edge earlier. The vector is combinational from status and enable, so it is checked right after the edge that updates either of them. The request is checked once at that point, where it must still show the old value, and again one edge later. For the clear-versus-event case, the write strobe is placed so that it is sampled on the same edge that registers the falling-edge event.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STS,
      SEL_EN,
      SEL_TYP,
      SEL_POL,
      SEL_HOLD,
      SEL_FALL,
      SEL_RISE
   } reg_sel_e;

   // word pair base: +0 low group, +2 high group
   function automatic reg_sel_e decode_sel(input logic [5:0] addr);
      case ({addr[5:2], 2'b00})
         6'h08:   return SEL_STS;
         6'h0C:   return SEL_EN;
         6'h10:   return SEL_TYP;
         6'h14:   return SEL_POL;
         6'h18:   return SEL_HOLD;
         6'h20:   return SEL_FALL;
         6'h24:   return SEL_RISE;
         default: return SEL_NONE;
      endcase
   endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("gpio_irq_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][W-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
      end else begin
         chain_q[0] <= d_i;
         for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
      end
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] s_i,
   input  logic [W-1:0] typ_i,
   input  logic [W-1:0] pol_i,
   input  logic [W-1:0] hold_i,
   input  logic [W-1:0] fall_i,
   input  logic [W-1:0] rise_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] sts_o
);
   logic [W-1:0] prev_q;
   logic [W-1:0] sts_q;
   logic [W-1:0] nxt;
   logic [W-1:0] edge_ev;

   for (genvar p = 0; p < W; p++) begin : g_pin
      assign edge_ev[p] = (s_i[p] & ~prev_q[p] & rise_i[p])
                        | (~s_i[p] & prev_q[p] & fall_i[p]);
      assign nxt[p] = !typ_i[p] ? (s_i[p] == pol_i[p])
                    : hold_i[p] ? (edge_ev[p] | (sts_q[p] & ~clr_i[p]))
                    : edge_ev[p];

      p_level_tracks_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!typ_i[p] && (s_i[p] == pol_i[p])) |=> sts_q[p]);
      p_level_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (!typ_i[p] && (s_i[p] != pol_i[p])) |=> !sts_q[p]);
      p_edge_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (typ_i[p] && !hold_i[p] && (s_i[p] == prev_q[p])) |=> !sts_q[p]);
      p_hold_keeps_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (typ_i[p] && hold_i[p] && sts_q[p] && !clr_i[p]) |=> sts_q[p]);
      p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (typ_i[p] && clr_i[p] && s_i[p] && !prev_q[p] && rise_i[p]) |=> sts_q[p]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         sts_q  <= '0;
      end else begin
         prev_q <= s_i;
         sts_q  <= nxt;
      end
   end

   assign sts_o = sts_q;
endmodule

// File: rtl/gpio_irq_prio.sv
module gpio_irq_prio #(
   parameter int W     = 32,
   parameter int LOW_W = 16,
   localparam int VEC_W = $clog2(W)
) (
   input  logic [W-1:0]     req_i,
   output logic             valid_o,
   output logic [VEC_W-1:0] idx_o
);
   always_comb begin
      valid_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (req_i[i]) begin
            valid_o = 1'b1;
            idx_o   = VEC_W'(i);
         end
      end
   end

   always_comb begin
      if (valid_o && (|req_i[LOW_W-1:0]))
         p_low_first_r8: assert (int'(idx_o) < LOW_W);
   end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
   parameter int NPINS       = 32,
   parameter int REG_W       = 16,
   parameter int SYNC_STAGES = 2,
   localparam int VEC_W      = $clog2(NPINS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pin_in,
   input  logic             bus_we,
   input  logic [5:0]       bus_addr,
   input  logic [REG_W-1:0] bus_wdata,
   output logic [REG_W-1:0] bus_rdata,
   output logic             irq,
   output logic             vec_valid,
   output logic [VEC_W-1:0] vec_pin
);
   import gpio_irq_pkg::*;

   localparam int NGRP = NPINS / REG_W;

   if ((NPINS % REG_W) != 0 || NGRP < 1 || NGRP > 2) begin : g_bad_geometry
      $error("gpio_irq_unit: NPINS must be one or two register words");
   end

   logic [NPINS-1:0] en_q, typ_q, pol_q, hold_q, fall_q, rise_q;
   logic [NPINS-1:0] sync_s, sts, clr;
   logic             irq_q;
   reg_sel_e         sel;
   int               grp;
   logic             grp_ok;

   assign sel    = decode_sel(bus_addr);
   assign grp    = int'(bus_addr[1]);
   assign grp_ok = (grp < NGRP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= '0;
         typ_q  <= '0;
         pol_q  <= '0;
         hold_q <= '0;
         fall_q <= '0;
         rise_q <= '0;
      end else if (bus_we && grp_ok) begin
         case (sel)
            SEL_EN:   en_q[grp*REG_W +: REG_W]   <= bus_wdata;
            SEL_TYP:  typ_q[grp*REG_W +: REG_W]  <= bus_wdata;
            SEL_POL:  pol_q[grp*REG_W +: REG_W]  <= bus_wdata;
            SEL_HOLD: hold_q[grp*REG_W +: REG_W] <= bus_wdata;
            SEL_FALL: fall_q[grp*REG_W +: REG_W] <= bus_wdata;
            SEL_RISE: rise_q[grp*REG_W +: REG_W] <= bus_wdata;
            default: ;
         endcase
      end
   end

   always_comb begin
      clr = '0;
      if (bus_we && grp_ok && sel == SEL_STS) clr[grp*REG_W +: REG_W] = bus_wdata;
   end

   always_comb begin
      bus_rdata = '0;
      if (grp_ok) begin
         case (sel)
            SEL_STS:  bus_rdata = sts[grp*REG_W +: REG_W];
            SEL_EN:   bus_rdata = en_q[grp*REG_W +: REG_W];
            SEL_TYP:  bus_rdata = typ_q[grp*REG_W +: REG_W];
            SEL_POL:  bus_rdata = pol_q[grp*REG_W +: REG_W];
            SEL_HOLD: bus_rdata = hold_q[grp*REG_W +: REG_W];
            SEL_FALL: bus_rdata = fall_q[grp*REG_W +: REG_W];
            SEL_RISE: bus_rdata = rise_q[grp*REG_W +: REG_W];
            default:  bus_rdata = '0;
         endcase
      end
   end

   gpio_irq_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_in),
      .q_o   (sync_s)
   );

   gpio_irq_detect #(.W(NPINS)) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .s_i    (sync_s),
      .typ_i  (typ_q),
      .pol_i  (pol_q),
      .hold_i (hold_q),
      .fall_i (fall_q),
      .rise_i (rise_q),
      .clr_i  (clr),
      .sts_o  (sts)
   );

   gpio_irq_prio #(.W(NPINS), .LOW_W(REG_W)) u_prio (
      .req_i   (sts & en_q),
      .valid_o (vec_valid),
      .idx_o   (vec_pin)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(sts & en_q);
   end

   assign irq = irq_q;

   p_irq_lags_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> $past(vec_valid));
   p_vec_qualifies_r9: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> (sts[vec_pin] && en_q[vec_pin]));
endmodule

// File: tb/gpio_irq_unit_test.sv
`timescale 1ns/1ps
module gpio_irq_unit_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] pins = 32'hFFFF_FFFF;
   logic        bus_we = 1'b0;
   logic [5:0]  bus_addr = 6'h00;
   logic [15:0] bus_wdata = 16'h0000;
   logic [15:0] bus_rdata;
   logic        irq, vec_valid;
   logic [4:0]  vec_pin;
   int          n_chk = 0;
   int          n_err = 0;

   always #2 clk = ~clk;

   gpio_irq_unit uut (
      .clk(clk), .rst_n(rst_n), .pin_in(pins), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq(irq), .vec_valid(vec_valid), .vec_pin(vec_pin)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_err++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic wait_edges(input int n);
      repeat (n) @(posedge clk);
      #0.5;
   endtask

   task automatic wr(input logic [5:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #0.5;
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [15:0] d);
      bus_addr = a;
      #0.1;
      d = bus_rdata;
   endtask

   task automatic exp_bit(input logic [5:0] a, input int b, input logic e, input string tag);
      logic [15:0] d;
      rd(a, d);
      check(tag, 32'(d[b]), 32'(e));
   endtask

   task automatic setpin(input int idx, input logic v);
      @(negedge clk);
      pins[idx] = v;
   endtask

   // R1
   task automatic t_reset();
      logic [15:0] d;
      rst_n = 1'b0;
      wait_edges(2);
      @(negedge clk) rst_n = 1'b1;
      wait_edges(6);
      for (int a = 8; a <= 38; a += 2) begin
         if (a == 28 || a == 30) continue;
         rd(6'(a), d);
         check($sformatf("R1 reset value at %0h", a), 32'(d), 32'h0);
      end
      check("R1 irq after reset", 32'(irq), 32'h0);
      check("R1 vec_valid after reset", 32'(vec_valid), 32'h0);
   endtask

   // R2
   task automatic t_level();
      setpin(5, 1'b0);
      wait_edges(2);
      exp_bit(6'h08, 5, 1'b0, "R2 level latency not yet");
      wait_edges(1);
      exp_bit(6'h08, 5, 1'b1, "R2 active-low asserted");
      wr(6'h18, 16'h0020);
      setpin(5, 1'b1);
      wait_edges(3);
      exp_bit(6'h08, 5, 1'b0, "R2 hold ignored in level mode");
      wr(6'h14, 16'h0020);
      wait_edges(1);
      exp_bit(6'h08, 5, 1'b1, "R2 active-high asserted");
      setpin(5, 1'b0);
      wait_edges(3);
      exp_bit(6'h08, 5, 1'b0, "R2 active-high released");
      wr(6'h14, 16'h0000);
      wr(6'h18, 16'h0000);
      setpin(5, 1'b1);
      wait_edges(3);
   endtask

   // R3 R4 on pin 21 (high word bit 5)
   task automatic t_edge();
      wr(6'h12, 16'h0020);
      wr(6'h26, 16'h0020);
      setpin(21, 1'b0);
      wait_edges(3);
      exp_bit(6'h0A, 5, 1'b0, "R3 falling ignored with rise only");
      setpin(21, 1'b1);
      wait_edges(2);
      exp_bit(6'h0A, 5, 1'b0, "R3 rising latency not yet");
      wait_edges(1);
      exp_bit(6'h0A, 5, 1'b1, "R3 rising detected");
      wait_edges(1);
      exp_bit(6'h0A, 5, 1'b0, "R4 pass-through lasts one cycle");
      wr(6'h22, 16'h0020);
      wr(6'h26, 16'h0000);
      setpin(21, 1'b0);
      wait_edges(3);
      exp_bit(6'h0A, 5, 1'b1, "R3 falling detected");
      setpin(21, 1'b1);
      wait_edges(3);
      exp_bit(6'h0A, 5, 1'b0, "R3 rising ignored with fall only");
      wr(6'h26, 16'h0020);
      setpin(21, 1'b0);
      wait_edges(3);
      exp_bit(6'h0A, 5, 1'b1, "R3 both: falling");
      setpin(21, 1'b1);
      wait_edges(3);
      exp_bit(6'h0A, 5, 1'b1, "R3 both: rising");
      wr(6'h12, 16'h0000);
      wr(6'h22, 16'h0000);
      wr(6'h26, 16'h0000);
   endtask

   // R4 R5 R6 on pin 2
   task automatic t_hold_clear();
      wr(6'h10, 16'h0004);
      wr(6'h24, 16'h0004);
      wr(6'h18, 16'h0004);
      setpin(2, 1'b0);
      setpin(2, 1'b1);
      wait_edges(3);
      exp_bit(6'h08, 2, 1'b1, "R4 hold captures rising");
      wait_edges(5);
      exp_bit(6'h08, 2, 1'b1, "R4 hold keeps status");
      wr(6'h08, 16'h0000);
      exp_bit(6'h08, 2, 1'b1, "R5 zero write leaves bit");
      wr(6'h08, 16'hFFFB);
      exp_bit(6'h08, 2, 1'b1, "R5 other ones leave bit");
      wr(6'h08, 16'h0004);
      exp_bit(6'h08, 2, 1'b0, "R5 one clears bit");
      setpin(2, 1'b0);
      setpin(2, 1'b1);
      wait_edges(3);
      wr(6'h20, 16'h0004);
      setpin(2, 1'b0);
      @(posedge clk);
      @(posedge clk);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = 6'h08; bus_wdata = 16'h0004;
      @(posedge clk);
      #0.5;
      bus_we = 1'b0;
      exp_bit(6'h08, 2, 1'b1, "R6 new event beats clear");
      wr(6'h08, 16'h0004);
      exp_bit(6'h08, 2, 1'b0, "R6 later clear works");
      wr(6'h10, 16'h0000);
      wr(6'h20, 16'h0000);
      wr(6'h24, 16'h0000);
      wr(6'h18, 16'h0000);
      setpin(2, 1'b1);
      wait_edges(3);
   endtask

   // R7 R8 R9
   task automatic t_vector();
      logic [15:0] d;
      setpin(18, 1'b0);
      setpin(20, 1'b0);
      wait_edges(3);
      wr(6'h0E, 16'h0014);
      check("R8 vec valid high word", 32'(vec_valid), 32'h1);
      check("R8 lowest high pin", 32'(vec_pin), 32'd18);
      check("R7 irq one edge late", 32'(irq), 32'h0);
      wait_edges(1);
      check("R7 irq asserted", 32'(irq), 32'h1);
      setpin(9, 1'b0);
      wait_edges(3);
      wr(6'h0C, 16'h0200);
      check("R8 low word wins", 32'(vec_pin), 32'd9);
      wr(6'h0C, 16'h0000);
      check("R8 back to high word", 32'(vec_pin), 32'd18);
      wr(6'h0E, 16'h0000);
      check("R9 no source valid low", 32'(vec_valid), 32'h0);
      check("R9 no source vec zero", 32'(vec_pin), 32'h0);
      check("R7 irq holds old value", 32'(irq), 32'h1);
      wait_edges(1);
      check("R7 irq drops", 32'(irq), 32'h0);
      rd(6'h0A, d);
      check("R9 status still pending", 32'(d), 32'h0014);
      setpin(9, 1'b1);
      setpin(18, 1'b1);
      setpin(20, 1'b1);
      wait_edges(3);
   endtask

   // R10
   task automatic t_readback();
      logic [15:0] d;
      for (int a = 12; a <= 38; a += 2) begin
         if (a == 28 || a == 30) continue;
         wr(6'(a), 16'(a) * 16'h0101 ^ 16'hA5A5);
      end
      for (int a = 12; a <= 38; a += 2) begin
         if (a == 28 || a == 30) continue;
         rd(6'(a), d);
         check($sformatf("R10 readback at %0h", a), 32'(d), 32'(16'(a) * 16'h0101 ^ 16'hA5A5));
      end
      rd(6'h1C, d);
      check("R10 unmapped reads zero", 32'(d), 32'h0);
   endtask

   initial begin
      #400000;
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      t_reset();
      t_level();
      t_edge();
      t_hold_clear();
      t_vector();
      t_readback();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule